// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns 32-bit sample words taken from a transmit FIFO into a serial audio stream in standard I2S format, acting as clock master. It produces the bit clock, the word select and the serial data. The bit clock comes from the block's own clock, which is the master audio clock, divided by a programmable 8-bit ratio. A resolution input selects 16 or 32 bits per channel. Only the low bits of each word are transmitted, most significant first.

Setting the enable starts a stream. The block first sends a one-bit lead-in with word select low, then a whole frame of silence, and only then starts to drain the FIFO. The FIFO has data valid at its head whenever it is not empty. Each frame takes two words, left and then right. If the FIFO is empty when a channel slot begins, that slot carries zeros and nothing is popped. Clearing the enable lets the current frame run to its end; after that all outputs rest low.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `sck`, `ws`, `sd` and `fifo_pop` are all low.
- R2: While a stream runs, `sck` is high for exactly ratio+2 clock cycles and low for exactly ratio+2 clock cycles, so the period is 2*(ratio+2) cycles.
- R3: When a stream starts, the block first sends one lead-in bit with `ws` low and `sd` low. It then sends a full frame of zeros (left slot, then right slot), and it pops nothing until the edge that ends that frame.
- R4: Every channel slot lasts `res_bits` bit clocks, where `res_bits` is 16 or 32. The slot carries bits res_bits-1 down to 0 of its word, most significant first. Word bits at or above res_bits are ignored.
- R5: `ws` is 0 for the left slot and 1 for the right slot. It takes the value of the next slot during the last bit of the current slot, one bit clock before that slot's first bit.
- R6: `sd` and `ws` change only on the clock edge where `sck` falls, so a receiver samples them on the rising `sck` edge.
- R7: A data slot that finds the FIFO non-empty pops exactly one word, with a one-cycle `fifo_pop`, on the edge where `sck` falls and the slot begins. In that cycle the word is taken from `fifo_data`. Words fill the left slot and then the right slot.
- R8: If `fifo_empty` is high when a data slot begins, the slot sends zeros and `fifo_pop` stays low.
- R9: When `tx_en` is low at the end of a frame (the falling `sck` edge after the right slot's last bit), the block stops at that edge and becomes idle. Clearing `tx_en` earlier in the frame does not cut the frame short.
- R10: `ratio` and `res_bits` are captured when a stream starts. Changing them while the stream runs has no effect on its timing or its slot length.
- R11: Enabling again after a stop starts a new stream, again with the lead-in bit and a silent frame before any FIFO data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Starts a stream when high; clearing it ends the stream at the next frame end |
| ratio | input | RATIO_W | Bit clock divider setting; each half period lasts ratio+2 clocks |
| res_bits | input | RES_W | Bits per channel slot, 16 or 32 |
| fifo_data | input | WORD_W | Word at the head of the FIFO, valid while fifo_empty is low |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | One-cycle request that consumes the head word |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 for left and 1 for right |
| sd | output | 1 | Serial data, MSB first |

## Verification
The embedded properties assume that `res_bits` holds 16 or 32 in any cycle where an idle block sees `tx_en` high. They also assume a show-ahead FIFO: the head word is on `fifo_data` whenever `fifo_empty` is low, and it leaves on the edge where `fifo_pop` is high. The bench models exactly such a FIFO and changes its fill pointer only between clock edges. It programs only the two legal resolutions at each start. It changes `ratio` and `res_bits` in the middle of one stream to show that the captured values govern the stream.

// File: rtl/pcm_tx_pkg.sv
// Shared definitions for the I2S transmit serializer.
// Holds the default widths and the stream phase encoding used by the sequencer.
package pcm_tx_pkg;
    localparam int DEF_WORD_W  = 32;
    localparam int DEF_RATIO_W = 8;

    // Stream phase: idle, one lead-in bit, the silent frame, and FIFO data frames.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_ZERO = 2'd2,
        ST_DATA = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/pcm_bclk_div.sv
// Bit clock divider.
// Counts master clock cycles while the stream runs and toggles sck after every
// ratio+2 cycles. It also flags the cycle whose edge turns sck from high to low.
// Assumes: ratio is held constant while run is high (the sequencer latches it).
module pcm_bclk_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               sck,
    output logic               fall_evt
);
    localparam int CNT_W = RATIO_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_lim;
    logic             tick;

    // Last count value of a half period (ratio+2 cycles: 0 .. ratio+1).
    assign half_lim = CNT_W'(ratio) + CNT_W'(1);
    assign tick     = run && (cnt == half_lim);
    assign fall_evt = tick && sck;

    // Half-period counter and bit clock register; both rest at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half_lim));

    // R1
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sck);
endmodule

// File: rtl/pcm_frame_seq.sv
// Frame sequencer.
// Tracks the stream phase, the channel and the bit position inside a slot, and
// drives word select. At each falling bit clock edge it either shifts to the
// next bit, or it starts a new slot: load a word (popping the FIFO in data
// frames), or stop when enable is low at the end of a frame.
// Assumes: res_in is WORD_W or WORD_W/2 when a stream starts; the FIFO shows its
// head word whenever fifo_empty is low.
module pcm_frame_seq
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [RES_W-1:0]   res_in,
    input  logic               fall_evt,
    input  logic               fifo_empty,
    output logic               run,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RES_W-1:0]   res_q,
    output logic               ws,
    output logic               slot_start,
    output logic               shift,
    output logic               stop_now,
    output logic               fifo_pop
);
    tx_phase_e        phase;
    tx_phase_e        next_phase;
    logic             ch;
    logic [RES_W-1:0] bitcnt;
    logic [RES_W-1:0] bitcnt_nx;
    logic             last_bit;
    logic             frame_end;

    assign run       = (phase != ST_IDLE);
    assign last_bit  = (bitcnt == res_q - RES_W'(1));
    assign frame_end = last_bit && ch;
    assign bitcnt_nx = bitcnt + RES_W'(1);

    // Phase that follows the current falling edge.
    always_comb begin
        next_phase = phase;
        if (frame_end) begin
            if (!tx_en)                next_phase = ST_IDLE;
            else if (phase == ST_LEAD) next_phase = ST_ZERO;
            else                       next_phase = ST_DATA;
        end
    end

    assign stop_now   = fall_evt && frame_end && !tx_en;
    assign slot_start = fall_evt && last_bit && !stop_now;
    assign shift      = fall_evt && !last_bit;
    assign fifo_pop   = slot_start && (next_phase == ST_DATA) && !fifo_empty;

    // Phase, channel, bit position and word select, advanced on falling sck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= ST_IDLE;
            ch      <= 1'b0;
            bitcnt  <= '0;
            ws      <= 1'b0;
            ratio_q <= '0;
            res_q   <= '0;
        end else if (phase == ST_IDLE) begin
            if (tx_en) begin
                // Lead-in acts as the last bit of a right slot: ws already low.
                phase   <= ST_LEAD;
                ratio_q <= ratio_in;
                res_q   <= res_in;
                ch      <= 1'b1;
                bitcnt  <= res_in - RES_W'(1);
                ws      <= 1'b0;
            end
        end else if (fall_evt) begin
            phase <= next_phase;
            if (stop_now) begin
                ch     <= 1'b0;
                bitcnt <= '0;
                ws     <= 1'b0;
            end else if (last_bit) begin
                ch     <= ~ch;
                bitcnt <= '0;
                ws     <= ~ch;
            end else begin
                bitcnt <= bitcnt_nx;
                ws     <= (bitcnt_nx == res_q - RES_W'(1)) ? ~ch : ch;
            end
        end
    end

    // R4
    res_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE && tx_en) |-> (res_in == RES_W'(WORD_W) || res_in == RES_W'(WORD_W / 2)));

    // R4
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bitcnt < res_q));

    // R7
    pop_into_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (phase == ST_DATA));

    // R3
    lead_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LEAD) |-> !fifo_pop);
endmodule

// File: rtl/pcm_shifter.sv
// Output shift register.
// On a slot start it aligns the low res bits of the word to the top and shows
// the MSB at once; on each later falling edge it moves to the next bit. A stop
// clears the data line.
// Assumes: load, shift and clear are never high together.
module pcm_shifter #(
    parameter int WORD_W = 32,
    parameter int RES_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [WORD_W-1:0] word,
    input  logic [RES_W-1:0]  res,
    output logic              sd
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] aligned;

    // Drop the unused upper bits by moving the slot's MSB to the top.
    assign aligned = word << (RES_W'(WORD_W) - res);

    // Serial data register and remaining bits of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            sd    <= 1'b0;
        end else if (load) begin
            sd    <= aligned[WORD_W-1];
            shreg <= aligned << 1;
        end else if (shift) begin
            sd    <= shreg[WORD_W-1];
            shreg <= shreg << 1;
        end
    end

    // R8
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word == '0) |=> !sd);

    // R9
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sd);
endmodule

// File: rtl/pcm_serial_tx.sv
// I2S transmit serializer, clock master.
// Drains 32-bit words from a show-ahead FIFO into an I2S stream. The stream has
// a lead-in bit and a silent frame first, pads underruns with zeros, and stops
// only at a frame end.
// Assumes: clk is the master audio clock; res_bits is 16 or 32 at start.
module pcm_serial_tx #(
    parameter int  WORD_W  = pcm_tx_pkg::DEF_WORD_W,
    parameter int  RATIO_W = pcm_tx_pkg::DEF_RATIO_W,
    localparam int RES_W   = $clog2(WORD_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   res_bits,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               sck,
    output logic               ws,
    output logic               sd
);
    logic               run;
    logic               fall_evt;
    logic [RATIO_W-1:0] ratio_q;
    logic [RES_W-1:0]   res_q;
    logic               slot_start;
    logic               shift;
    logic               stop_now;
    logic [WORD_W-1:0]  slot_word;

    // Data slots take the FIFO head when popping; all other slots send zeros.
    assign slot_word = fifo_pop ? fifo_data : '0;

    pcm_bclk_div #(.RATIO_W(RATIO_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ratio    (ratio_q),
        .sck      (sck),
        .fall_evt (fall_evt)
    );

    pcm_frame_seq #(.WORD_W(WORD_W), .RATIO_W(RATIO_W), .RES_W(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .ratio_in   (ratio),
        .res_in     (res_bits),
        .fall_evt   (fall_evt),
        .fifo_empty (fifo_empty),
        .run        (run),
        .ratio_q    (ratio_q),
        .res_q      (res_q),
        .ws         (ws),
        .slot_start (slot_start),
        .shift      (shift),
        .stop_now   (stop_now),
        .fifo_pop   (fifo_pop)
    );

    pcm_shifter #(.WORD_W(WORD_W), .RES_W(RES_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (slot_start),
        .shift (shift),
        .clear (stop_now),
        .word  (slot_word),
        .res   (res_q),
        .sd    (sd)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!sck && !ws && !sd && !fifo_pop));

    // R6
    edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(sck) && !sck) |-> ($stable(ws) && $stable(sd)));

    // R7
    pop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> ($past(sck) && !sck));

    // R8
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);
endmodule

// File: tb/pcm_serial_tx_tb.sv
// Directed bench: a show-ahead FIFO model, an I2S receiver that samples on rising
// sck, and one task per scenario comparing the received stream to one built here.
module pcm_serial_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = 8'd0;
    logic [5:0]  res_bits = 6'd32;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        sck, ws, sd;

    logic [31:0] fifo_mem [0:63];
    int rd_ptr = 0;
    int wr_ptr = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit cap_ws [0:511];
    bit cap_sd [0:511];
    bit exp_ws [0:511];
    bit exp_sd [0:511];
    int cap_n = 0;
    int exp_n = 0;
    int pop_cnt = 0;
    int first_pop_cap = -1;
    int cyc = 0;
    int last_rise = -1;
    int bad_period = 0;
    int bad_hi = 0;
    int h_exp = 2;
    bit sck_prev = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = fifo_mem[rd_ptr[5:0]];

    pcm_serial_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .ratio      (ratio),
        .res_bits   (res_bits),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .sck        (sck),
        .ws         (ws),
        .sd         (sd)
    );

    // FIFO head advances on the edge that sees the pop.
    always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

    // Receiver and timing monitor, sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (sck && !sck_prev) begin
            if (cap_n < 512) begin
                cap_ws[cap_n] = ws;
                cap_sd[cap_n] = sd;
            end
            if (last_rise >= 0 && (cyc - last_rise) != 2 * h_exp) bad_period++;
            last_rise = cyc;
            cap_n++;
        end
        if (!sck && sck_prev && (cyc - last_rise) != h_exp) bad_hi++;
        if (fifo_pop) begin
            if (pop_cnt == 0) first_pop_cap = cap_n;
            pop_cnt++;
        end
        sck_prev = sck;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fifo_mem[wr_ptr[5:0]] = w;
        wr_ptr++;
    endtask

    task automatic exp_bit(input bit w, input bit s);
        exp_ws[exp_n] = w;
        exp_sd[exp_n] = s;
        exp_n++;
    endtask

    // One slot: ws shows the next channel during the last bit; MSB first.
    task automatic exp_slot(input logic [31:0] w, input bit ch, input int n);
        for (int b = 0; b < n; b++)
            exp_bit((b == n - 1) ? ~ch : ch, w[n - 1 - b]);
    endtask

    // Lead-in bit plus the silent frame.
    task automatic exp_head(input int n);
        exp_n = 0;
        exp_bit(1'b0, 1'b0);
        exp_slot(32'd0, 1'b0, n);
        exp_slot(32'd0, 1'b1, n);
    endtask

    task automatic start(input int r, input int n);
        step();
        ratio = 8'(r);
        res_bits = 6'(n);
        h_exp = r + 2;
        cap_n = 0;
        pop_cnt = 0;
        first_pop_cap = -1;
        last_rise = -1;
        bad_period = 0;
        bad_hi = 0;
        tx_en = 1'b1;
    endtask

    task automatic wait_pops(input int k);
        while (pop_cnt < k) step();
    endtask

    task automatic stop_and_settle(input int n);
        tx_en = 1'b0;
        repeat (4 * h_exp * (n + 4)) step();
    endtask

    // Compare the received stream, pops, bit clock timing and the idle state.
    task automatic verify(input string req, input int exp_pops);
        int bad = -1;
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && (cap_ws[i] != exp_ws[i] || cap_sd[i] != exp_sd[i])) bad = i;
        chk(cap_n == exp_n, {req, " bit count"}, cap_n, exp_n);
        chk(bad < 0, {req, " R4 R5 R6 first mismatching bit"}, bad, -1);
        chk(pop_cnt == exp_pops, {req, " R7 pop count"}, pop_cnt, exp_pops);
        chk(bad_period == 0, {req, " R2 period errors"}, bad_period, 0);
        chk(bad_hi == 0, {req, " R2 high-half errors"}, bad_hi, 0);
        chk(!sck && !ws && !sd && !fifo_pop, {req, " R1 R9 idle outputs"},
            int'({sck, ws, sd, fifo_pop}), 0);
    endtask

    // R1: outputs after reset.
    task automatic t_reset();
        repeat (3) step();
        rst_n = 1'b1;
        repeat (5) step();
        chk(!sck && !ws && !sd && !fifo_pop, "R1 reset outputs",
            int'({sck, ws, sd, fifo_pop}), 0);
    endtask

    // R3 R7 R10: 32-bit stereo, silent frame first, config changed mid-stream.
    task automatic t_stereo32();
        logic [31:0] w [4] = '{32'hA5C3_0F81, 32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_5678};
        for (int i = 0; i < 4; i++) push(w[i]);
        start(0, 32);
        repeat (3) step();
        ratio = 8'd5;
        res_bits = 6'd16;
        wait_pops(4);
        stop_and_settle(32);
        exp_head(32);
        for (int i = 0; i < 4; i++) exp_slot(w[i], i[0], 32);
        verify("R3 R10 stereo32", 4);
        chk(first_pop_cap == 1 + 64, "R3 first pop after silent frame", first_pop_cap, 65);
    endtask

    // R4: 16-bit slots send only the low half of each word.
    task automatic t_res16();
        push(32'hDEAD_8001);
        push(32'hBEEF_7FFE);
        start(2, 16);
        wait_pops(2);
        stop_and_settle(16);
        exp_head(16);
        exp_slot(32'h0000_8001, 1'b0, 16);
        exp_slot(32'h0000_7FFE, 1'b1, 16);
        verify("R4 res16", 2);
    endtask

    // R8: odd word count leaves the last right slot empty.
    task automatic t_underrun();
        push(32'hF000_000F);
        push(32'h0F0F_0F0F);
        push(32'hC000_0003);
        start(1, 32);
        wait_pops(3);
        stop_and_settle(32);
        exp_head(32);
        exp_slot(32'hF000_000F, 1'b0, 32);
        exp_slot(32'h0F0F_0F0F, 1'b1, 32);
        exp_slot(32'hC000_0003, 1'b0, 32);
        exp_slot(32'h0, 1'b1, 32);
        verify("R8 underrun", 3);
        chk(fifo_empty, "R8 fifo drained", int'(fifo_empty), 1);
    endtask

    // R9: enable cleared in a left slot; the frame still completes.
    task automatic t_stop_mid();
        push(32'h0000_A001);
        push(32'h0000_5002);
        push(32'h0000_C3C3);
        push(32'h0000_3C3C);
        start(0, 16);
        wait_pops(1);
        stop_and_settle(16);
        exp_head(16);
        exp_slot(32'h0000_A001, 1'b0, 16);
        exp_slot(32'h0000_5002, 1'b1, 16);
        verify("R9 stop mid frame", 2);
    endtask

    // R11: restart sends a lead-in and silent frame again before the remaining words.
    task automatic t_restart();
        start(0, 16);
        wait_pops(2);
        stop_and_settle(16);
        exp_head(16);
        exp_slot(32'h0000_C3C3, 1'b0, 16);
        exp_slot(32'h0000_3C3C, 1'b1, 16);
        verify("R11 restart", 2);
    endtask

    initial begin
        t_reset();
        t_stereo32();
        t_res16();
        t_underrun();
        t_stop_mid();
        t_restart();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule